// File: doc/BRIEF.md
# Tree Memory-Module Rank Router

This block is the steering core of a buffer device placed on every memory module of a module tree. Command/address transactions, with their write data, come in from the parent side. Read data comes back up from the child side. For each incoming command the block reads a small programmable table indexed by the rank tag. The table entry gives one of four decisions:

- deliver to the DRAM attached to this module;
- forward one level down through a per-channel buffer;
- send back toward the parent;
- discard.

Every forwarding path holds exactly one register stage. A transaction accepted on one clock edge is therefore presented at its destination right after that edge, which matches the one-cycle cost of a tree hop.

Local deliveries carry a one-hot chip select decoded from the binary rank tag. Child-bound traffic is split into independent buffers, one per logical channel, so a stalled channel never holds up another one. Returning read data always travels toward the parent, whatever the table says, and keeps its rank tag. It takes precedence over commands that are bounced upward in the same cycle. A discarded command sets an error flag that stays high until reset.

Top module: `tmod_rank_router`

## Requirements
- R1: After reset every table entry means "discard", all output valids are low, `loc_cs` is zero and `err_noroute` is low.
- R2: With `cfg_we` high at a rising edge, entry `cfg_rank` takes route code `cfg_route` and channel `cfg_chan`, and the new entry governs commands offered on later cycles. The route codes are 00 local, 01 child, 10 parent and 11 discard.
- R3: A command routed local and accepted at edge N appears on the `loc_*` outputs right after edge N with the same write flag, address and data. At that point bit `rank` of `loc_cs` is its only set bit. `loc_cs` is all zero whenever `loc_valid` is low.
- R4: A command routed child goes to the channel c stored in its entry. It appears one cycle after acceptance with `ch_valid[c]` high and its fields in slice c of each child bus (rank bits c*RANK_W and up, address bits c*ADDR_W and up, data bits c*DATA_W and up). No other channel and no other destination becomes valid.
- R5: A command routed parent appears on the `up_*` outputs one cycle after acceptance with `up_is_read` low and its rank, write flag, address and data intact.
- R6: A command whose entry is discard is accepted (`dn_ready` high) and shows up at no output. `err_noroute` is high from the following edge and stays high until reset.
- R7: A read return on `rd_in_*` appears on `up_*` one cycle after acceptance with `up_is_read` high, its own rank tag and data, whatever the table holds for that rank. If a parent-routed command is offered in the same cycle, the read return goes first and `dn_ready` is low.
- R8: Each destination buffer holds BUF_DEPTH entries and keeps its output stable while not taken. When the target buffer is full, `dn_ready` is low, and entries leave in arrival order.
- R9: A full buffer on one child channel does not block commands routed to another child channel.
- R10: When the parent-side buffer is full, `rd_in_ready` is low and no read return is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Route table write strobe |
| cfg_rank | input | RANK_W | Table entry to write |
| cfg_route | input | 2 | Route code to store |
| cfg_chan | input | CH_W | Child channel to store |
| dn_valid | input | 1 | Command offered from parent side |
| dn_ready | output | 1 | Command accepted this cycle |
| dn_rank | input | RANK_W | Binary rank tag of the command |
| dn_write | input | 1 | Command is a write |
| dn_addr | input | ADDR_W | Command address |
| dn_wdata | input | DATA_W | Write data |
| rd_in_valid | input | 1 | Read return offered from child side |
| rd_in_ready | output | 1 | Read return accepted |
| rd_in_rank | input | RANK_W | Rank tag of the read return |
| rd_in_data | input | DATA_W | Read data |
| loc_valid | output | 1 | Local DRAM command valid |
| loc_ready | input | 1 | Local DRAM side takes the command |
| loc_cs | output | NUM_RANKS | One-hot chip select |
| loc_write | output | 1 | Local command is a write |
| loc_addr | output | ADDR_W | Local address |
| loc_wdata | output | DATA_W | Local write data |
| ch_valid | output | NUM_CH | Per-channel child command valid |
| ch_ready | input | NUM_CH | Per-channel child side ready |
| ch_rank | output | NUM_CH*RANK_W | Per-channel rank tags |
| ch_write | output | NUM_CH | Per-channel write flags |
| ch_addr | output | NUM_CH*ADDR_W | Per-channel addresses |
| ch_wdata | output | NUM_CH*DATA_W | Per-channel write data |
| up_valid | output | 1 | Parent-bound item valid |
| up_ready | input | 1 | Parent side takes the item |
| up_is_read | output | 1 | 1 for read return, 0 for bounced command |
| up_rank | output | RANK_W | Rank tag |
| up_write | output | 1 | Write flag (0 for read return) |
| up_addr | output | ADDR_W | Address (0 for read return) |
| up_data | output | DATA_W | Read data or write data |
| err_noroute | output | 1 | Sticky flag for a discarded command |

## Verification
The bench sweeps every rank through each of the five routing choices: local, child channel 0, child channel 1, parent and discard. At each step it checks that exactly one destination fires, exactly one cycle after acceptance. A router that read a stale table entry, used the wrong channel field, or added or skipped a register stage would send the item to the wrong port or at the wrong cycle. Read returns are swept over every rank while every entry says discard, which catches a design that routes returns through the table. Collisions between a read return and a bounced command expose a reversed priority. Full buffers are driven on the local path, on one child channel and on the parent path, which catches lost items, broken ordering, and a stall that leaks from one channel into the other.

// File: rtl/tmr_pkg.sv
// Shared types for the tree-module rank router.
// Route codes are fixed by the configuration port encoding.
package tmr_pkg;

    typedef enum logic [1:0] {
        RT_LOCAL  = 2'b00,
        RT_CHILD  = 2'b01,
        RT_PARENT = 2'b10,
        RT_NONE   = 2'b11
    } route_e;

endpackage

// File: rtl/tmr_fifo.sv
// Small synchronous FIFO used as a one-stage forwarding buffer.
// Output comes from storage, so an entry pushed at edge N is visible
// right after edge N. Assumes DEPTH >= 1. No push while full (in_ready low).
module tmr_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CNTW-1:0]  count;
    logic             push;
    logic             pop;

    assign in_ready  = (count != CNTW'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

    // Advance pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/tmr_route_table.sv
// Per-rank routing table: one route code and one child-channel field per rank.
// Written through a single-entry port; read combinationally by rank tag.
// Reset sets every entry to RT_NONE. Assumes NUM_RANKS and NUM_CH are powers of two.
module tmr_route_table
    import tmr_pkg::*;
#(
    parameter int NUM_RANKS = 8,
    parameter int NUM_CH    = 2,
    localparam int RW = $clog2(NUM_RANKS),
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_rank,
    input  route_e        wr_route,
    input  logic [CW-1:0] wr_chan,
    input  logic [RW-1:0] rd_rank,
    output route_e        rd_route,
    output logic [CW-1:0] rd_chan
);
    route_e        route_q [NUM_RANKS];
    logic [CW-1:0] chan_q  [NUM_RANKS];

    // Hold the table; reset clears every entry to "discard".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RANKS; i++) begin
                route_q[i] <= RT_NONE;
                chan_q[i]  <= '0;
            end
        end else if (wr_en) begin
            route_q[wr_rank] <= wr_route;
            chan_q[wr_rank]  <= wr_chan;
        end
    end

    assign rd_route = route_q[rd_rank];
    assign rd_chan  = chan_q[rd_rank];

endmodule

// File: rtl/tmr_cs_decode.sv
// Binary rank tag to one-hot chip select, gated by an enable.
// All outputs are zero when the enable is low.
module tmr_cs_decode #(
    parameter int NUM_RANKS = 8,
    localparam int RW = $clog2(NUM_RANKS)
) (
    input  logic                 en,
    input  logic [RW-1:0]        sel,
    output logic [NUM_RANKS-1:0] onehot
);
    for (genvar i = 0; i < NUM_RANKS; i++) begin : g_bit
        localparam logic [RW-1:0] IDX = RW'(i);
        assign onehot[i] = en && (sel == IDX);
    end

endmodule

// File: rtl/tmod_rank_router.sv
// Rank router for a buffer device on a memory module inside a module tree.
// Commands from the parent side are steered by a per-rank table to the local
// DRAM port, a per-channel child buffer, or back up; read returns from the
// child side always go up and win over same-cycle bounced commands.
// Every path holds one register stage (one-cycle hop). Assumes NUM_RANKS and
// NUM_CH are powers of two and BUF_DEPTH >= 1.
module tmod_rank_router
    import tmr_pkg::*;
#(
    parameter int NUM_RANKS = 8,
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BUF_DEPTH = 2,
    localparam int RANK_W = $clog2(NUM_RANKS),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [RANK_W-1:0]        cfg_rank,
    input  logic [1:0]               cfg_route,
    input  logic [CH_W-1:0]          cfg_chan,
    input  logic                     dn_valid,
    output logic                     dn_ready,
    input  logic [RANK_W-1:0]        dn_rank,
    input  logic                     dn_write,
    input  logic [ADDR_W-1:0]        dn_addr,
    input  logic [DATA_W-1:0]        dn_wdata,
    input  logic                     rd_in_valid,
    output logic                     rd_in_ready,
    input  logic [RANK_W-1:0]        rd_in_rank,
    input  logic [DATA_W-1:0]        rd_in_data,
    output logic                     loc_valid,
    input  logic                     loc_ready,
    output logic [NUM_RANKS-1:0]     loc_cs,
    output logic                     loc_write,
    output logic [ADDR_W-1:0]        loc_addr,
    output logic [DATA_W-1:0]        loc_wdata,
    output logic [NUM_CH-1:0]        ch_valid,
    input  logic [NUM_CH-1:0]        ch_ready,
    output logic [NUM_CH*RANK_W-1:0] ch_rank,
    output logic [NUM_CH-1:0]        ch_write,
    output logic [NUM_CH*ADDR_W-1:0] ch_addr,
    output logic [NUM_CH*DATA_W-1:0] ch_wdata,
    output logic                     up_valid,
    input  logic                     up_ready,
    output logic                     up_is_read,
    output logic [RANK_W-1:0]        up_rank,
    output logic                     up_write,
    output logic [ADDR_W-1:0]        up_addr,
    output logic [DATA_W-1:0]        up_data,
    output logic                     err_noroute
);
    localparam int TXN_W = RANK_W + 1 + ADDR_W + DATA_W;
    localparam int UP_W  = TXN_W + 1;

    route_e              lk_route;
    logic [CH_W-1:0]     lk_chan;
    logic [TXN_W-1:0]    dn_pkt;
    logic                loc_in_ready;
    logic                loc_push;
    logic [NUM_CH-1:0]   ch_in_ready;
    logic [NUM_CH-1:0]   ch_push;
    logic                up_in_ready;
    logic                bounce_push;
    logic                rd_push;
    logic                up_push;
    logic [UP_W-1:0]     up_din;
    logic [UP_W-1:0]     up_q;
    logic [TXN_W-1:0]    loc_q;
    logic [RANK_W-1:0]   loc_rank_q;

    assign dn_pkt = {dn_rank, dn_write, dn_addr, dn_wdata};

    tmr_route_table #(
        .NUM_RANKS (NUM_RANKS),
        .NUM_CH    (NUM_CH)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_rank  (cfg_rank),
        .wr_route (route_e'(cfg_route)),
        .wr_chan  (cfg_chan),
        .rd_rank  (dn_rank),
        .rd_route (lk_route),
        .rd_chan  (lk_chan)
    );

    // Steer the offered command and derive its ready from the target buffer.
    always_comb begin
        dn_ready    = 1'b0;
        loc_push    = 1'b0;
        ch_push     = '0;
        bounce_push = 1'b0;
        case (lk_route)
            RT_LOCAL: begin
                dn_ready = loc_in_ready;
                loc_push = dn_valid && loc_in_ready;
            end
            RT_CHILD: begin
                dn_ready         = ch_in_ready[lk_chan];
                ch_push[lk_chan] = dn_valid && ch_in_ready[lk_chan];
            end
            RT_PARENT: begin
                dn_ready    = up_in_ready && !rd_in_valid;
                bounce_push = dn_valid && up_in_ready && !rd_in_valid;
            end
            default: begin
                dn_ready = 1'b1;
            end
        endcase
    end

    // Merge read returns (first priority) with bounced commands toward the parent.
    assign rd_in_ready = up_in_ready;
    assign rd_push     = rd_in_valid && up_in_ready;
    assign up_push     = rd_push || bounce_push;
    assign up_din      = rd_in_valid
                         ? {1'b1, rd_in_rank, 1'b0, {ADDR_W{1'b0}}, rd_in_data}
                         : {1'b0, dn_pkt};

    // Latch a discarded command into the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_noroute <= 1'b0;
        end else if (dn_valid && (lk_route == RT_NONE)) begin
            err_noroute <= 1'b1;
        end
    end

    tmr_fifo #(
        .WIDTH (TXN_W),
        .DEPTH (BUF_DEPTH)
    ) u_loc_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (loc_push),
        .in_ready  (loc_in_ready),
        .in_data   (dn_pkt),
        .out_valid (loc_valid),
        .out_ready (loc_ready),
        .out_data  (loc_q)
    );

    assign {loc_rank_q, loc_write, loc_addr, loc_wdata} = loc_q;

    tmr_cs_decode #(
        .NUM_RANKS (NUM_RANKS)
    ) u_cs (
        .en     (loc_valid),
        .sel    (loc_rank_q),
        .onehot (loc_cs)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [TXN_W-1:0] q;

        tmr_fifo #(
            .WIDTH (TXN_W),
            .DEPTH (BUF_DEPTH)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (ch_push[c]),
            .in_ready  (ch_in_ready[c]),
            .in_data   (dn_pkt),
            .out_valid (ch_valid[c]),
            .out_ready (ch_ready[c]),
            .out_data  (q)
        );

        assign {ch_rank[c*RANK_W +: RANK_W], ch_write[c],
                ch_addr[c*ADDR_W +: ADDR_W], ch_wdata[c*DATA_W +: DATA_W]} = q;
    end

    tmr_fifo #(
        .WIDTH (UP_W),
        .DEPTH (BUF_DEPTH)
    ) u_up_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (up_push),
        .in_ready  (up_in_ready),
        .in_data   (up_din),
        .out_valid (up_valid),
        .out_ready (up_ready),
        .out_data  (up_q)
    );

    assign {up_is_read, up_rank, up_write, up_addr, up_data} = up_q;

endmodule

// File: rtl/tmr_router_checker.sv
// Protocol and behaviour checks for tmod_rank_router, attached by bind.
module tmr_router_checker #(
    parameter int NUM_RANKS = 8,
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 16,
    localparam int RANK_W = $clog2(NUM_RANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dn_valid,
    input logic                 dn_ready,
    input logic [1:0]           lk_route,
    input logic                 rd_in_valid,
    input logic                 rd_in_ready,
    input logic                 loc_valid,
    input logic                 loc_ready,
    input logic [NUM_RANKS-1:0] loc_cs,
    input logic [ADDR_W-1:0]    loc_addr,
    input logic [NUM_CH-1:0]    ch_valid,
    input logic [NUM_CH-1:0]    ch_ready,
    input logic                 up_valid,
    input logic                 up_ready,
    input logic                 up_is_read,
    input logic [RANK_W-1:0]    up_rank,
    input logic                 err_noroute
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!loc_valid && !up_valid && (ch_valid == '0) && !err_noroute));

    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |-> ($countones(loc_cs) == 1));

    p_cs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_valid |-> (loc_cs == '0));

    p_none_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && (lk_route == 2'b11)) |-> dn_ready);

    p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && (lk_route == 2'b11)) |=> err_noroute);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_noroute |=> err_noroute);

    p_read_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_valid && (lk_route == 2'b10)) |-> !dn_ready);

    p_read_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in_valid && rd_in_ready) |=> up_valid);

    p_loc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !loc_ready) |=> (loc_valid && $stable(loc_addr) && $stable(loc_cs)));

    p_up_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ready) |=> (up_valid && $stable(up_rank) && $stable(up_is_read)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        p_ch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_valid[c] && !ch_ready[c]) |=> ch_valid[c]);
    end

endmodule

bind tmod_rank_router tmr_router_checker #(
    .NUM_RANKS (NUM_RANKS),
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dn_valid    (dn_valid),
    .dn_ready    (dn_ready),
    .lk_route    (lk_route),
    .rd_in_valid (rd_in_valid),
    .rd_in_ready (rd_in_ready),
    .loc_valid   (loc_valid),
    .loc_ready   (loc_ready),
    .loc_cs      (loc_cs),
    .loc_addr    (loc_addr),
    .ch_valid    (ch_valid),
    .ch_ready    (ch_ready),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_is_read  (up_is_read),
    .up_rank     (up_rank),
    .err_noroute (err_noroute)
);

// File: tb/tmod_rank_router_bench.sv
// Sweep bench for tmod_rank_router: 8 ranks, 2 child channels, depth-2 buffers.
module tmod_rank_router_bench;
    localparam int NR = 8;
    localparam int NCH = 2;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [RW-1:0] cfg_rank = '0;
    logic [1:0] cfg_route = '0;
    logic cfg_chan = 1'b0;
    logic dn_valid = 1'b0;
    logic dn_ready;
    logic [RW-1:0] dn_rank = '0;
    logic dn_write = 1'b0;
    logic [AW-1:0] dn_addr = '0;
    logic [DW-1:0] dn_wdata = '0;
    logic rd_in_valid = 1'b0;
    logic rd_in_ready;
    logic [RW-1:0] rd_in_rank = '0;
    logic [DW-1:0] rd_in_data = '0;
    logic loc_valid;
    logic loc_ready = 1'b1;
    logic [NR-1:0] loc_cs;
    logic loc_write;
    logic [AW-1:0] loc_addr;
    logic [DW-1:0] loc_wdata;
    logic [NCH-1:0] ch_valid;
    logic [NCH-1:0] ch_ready = '1;
    logic [NCH*RW-1:0] ch_rank;
    logic [NCH-1:0] ch_write;
    logic [NCH*AW-1:0] ch_addr;
    logic [NCH*DW-1:0] ch_wdata;
    logic up_valid;
    logic up_ready = 1'b1;
    logic up_is_read;
    logic [RW-1:0] up_rank;
    logic up_write;
    logic [AW-1:0] up_addr;
    logic [DW-1:0] up_data;
    logic err_noroute;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmod_rank_router #(
        .NUM_RANKS (NR), .NUM_CH (NCH), .ADDR_W (AW), .DATA_W (DW), .BUF_DEPTH (2)
    ) u_tmod_rank_router (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_rank (cfg_rank), .cfg_route (cfg_route), .cfg_chan (cfg_chan),
        .dn_valid (dn_valid), .dn_ready (dn_ready), .dn_rank (dn_rank), .dn_write (dn_write),
        .dn_addr (dn_addr), .dn_wdata (dn_wdata),
        .rd_in_valid (rd_in_valid), .rd_in_ready (rd_in_ready), .rd_in_rank (rd_in_rank),
        .rd_in_data (rd_in_data),
        .loc_valid (loc_valid), .loc_ready (loc_ready), .loc_cs (loc_cs), .loc_write (loc_write),
        .loc_addr (loc_addr), .loc_wdata (loc_wdata),
        .ch_valid (ch_valid), .ch_ready (ch_ready), .ch_rank (ch_rank), .ch_write (ch_write),
        .ch_addr (ch_addr), .ch_wdata (ch_wdata),
        .up_valid (up_valid), .up_ready (up_ready), .up_is_read (up_is_read), .up_rank (up_rank),
        .up_write (up_write), .up_addr (up_addr), .up_data (up_data),
        .err_noroute (err_noroute)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] valids();
        return {loc_valid, ch_valid, up_valid};
    endfunction

    // Called at a negedge; returns at a negedge after the entry is written.
    task automatic cfg_write(input int r, input int code, input int chn);
        cfg_we = 1'b1; cfg_rank = RW'(r); cfg_route = 2'(code); cfg_chan = chn[0];
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Offer one command and check where it lands one cycle later.
    task automatic send_check(input int r, input int code, input int chn,
                              input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        dn_valid = 1'b1; dn_rank = RW'(r); dn_write = wr; dn_addr = a; dn_wdata = d;
        #1;
        chk("R8 ready offered to free target", 64'(dn_ready), 64'd1);
        chk("R3 R4 R5 nothing before the edge", 64'(valids()), 64'd0);
        @(posedge clk); @(negedge clk);
        dn_valid = 1'b0;
        case (code)
            0: begin
                chk("R3 only local valid", 64'(valids()), 64'b1000);
                chk("R3 one-hot select", 64'(loc_cs), 64'(1) << r);
                chk("R3 local payload", {loc_write, loc_addr, loc_wdata}, {wr, a, d});
            end
            1: begin
                chk("R4 only chosen channel valid", 64'(valids()),
                    (chn == 0) ? 64'b0010 : 64'b0100);
                chk("R4 channel payload",
                    {ch_rank[chn*RW +: RW], ch_write[chn], ch_addr[chn*AW +: AW], ch_wdata[chn*DW +: DW]},
                    {3'(r), wr, a, d});
                chk("R3 cs quiet without local", 64'(loc_cs), 64'd0);
            end
            2: begin
                chk("R5 only parent valid", 64'(valids()), 64'b0001);
                chk("R5 parent payload", {up_is_read, up_rank, up_write, up_addr, up_data},
                    {1'b0, 3'(r), wr, a, d});
            end
            default: begin
                chk("R6 dropped everywhere", 64'(valids()), 64'd0);
                chk("R6 error flag set", 64'(err_noroute), 64'd1);
            end
        endcase
        @(posedge clk); @(negedge clk);
    endtask

    task automatic try_send(input int r, input logic [AW-1:0] a, output bit acc);
        dn_valid = 1'b1; dn_rank = RW'(r); dn_write = 1'b0; dn_addr = a; dn_wdata = 32'(a);
        #1; acc = dn_ready;
        @(posedge clk); @(negedge clk);
        dn_valid = 1'b0;
    endtask

    task automatic try_read(input int r, input logic [DW-1:0] d, output bit acc);
        rd_in_valid = 1'b1; rd_in_rank = RW'(r); rd_in_data = d;
        #1; acc = rd_in_ready;
        @(posedge clk); @(negedge clk);
        rd_in_valid = 1'b0;
    endtask

    initial begin
        bit acc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 outputs idle in reset", 64'(valids()), 64'd0);
        chk("R1 error low in reset", 64'(err_noroute), 64'd0);
        chk("R1 cs zero in reset", 64'(loc_cs), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 read path ready after reset", 64'(rd_in_ready), 64'd1);
        chk("R1 error still low", 64'(err_noroute), 64'd0);
        // R1: untouched table discards a command
        send_check(5, 3, 0, 1'b1, 16'h0BAD, 32'hDEAD0005);

        // R2..R6 sweep: every rank through every route choice
        for (int r = 0; r < NR; r++) begin
            for (int k = 0; k < 5; k++) begin
                int code;
                int chn;
                code = (k == 0) ? 0 : (k <= 2) ? 1 : (k == 3) ? 2 : 3;
                chn  = (k == 2) ? 1 : 0;
                cfg_write(r, code, chn);
                send_check(r, code, chn, k[0], 16'(16'h1000 + r * 16 + k),
                           32'hA5000000 ^ 32'(r << 8) ^ 32'(k));
            end
        end
        chk("R6 error stays set", 64'(err_noroute), 64'd1);

        // R7: read returns ignore the table (all entries now discard)
        for (int r = 0; r < NR; r++) begin
            try_read(r, 32'h5EED0000 + 32'(r), acc);
            chk("R7 read accepted", 64'(acc), 64'd1);
            chk("R7 read lands on parent side",
                {valids(), up_is_read, up_rank, up_write, up_addr, up_data},
                {4'b0001, 1'b1, 3'(r), 1'b0, 16'h0, 32'h5EED0000 + 32'(r)});
            @(posedge clk); @(negedge clk);
        end

        // R7: read return beats a bounced command in the same cycle
        cfg_write(2, 2, 0);
        rd_in_valid = 1'b1; rd_in_rank = 3'd5; rd_in_data = 32'hFEED0055;
        dn_valid = 1'b1; dn_rank = 3'd2; dn_write = 1'b1; dn_addr = 16'h2222; dn_wdata = 32'h0;
        #1;
        chk("R7 read accepted in collision", 64'(rd_in_ready), 64'd1);
        chk("R7 command held back in collision", 64'(dn_ready), 64'd0);
        @(posedge clk); @(negedge clk);
        rd_in_valid = 1'b0;
        chk("R7 read first", {up_is_read, up_rank, up_data}, {1'b1, 3'd5, 32'hFEED0055});
        #1;
        chk("R5 command accepted after read", 64'(dn_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        dn_valid = 1'b0;
        chk("R5 bounced command second", {up_valid, up_is_read, up_rank, up_addr},
            {1'b1, 1'b0, 3'd2, 16'h2222});
        @(posedge clk); @(negedge clk);

        // R8: local buffer fills at two entries and drains in order
        cfg_write(1, 0, 0);
        loc_ready = 1'b0;
        try_send(1, 16'hA000, acc); chk("R8 first accepted", 64'(acc), 64'd1);
        try_send(1, 16'hA001, acc); chk("R8 second accepted", 64'(acc), 64'd1);
        try_send(1, 16'hA002, acc); chk("R8 full refuses", 64'(acc), 64'd0);
        chk("R8 oldest at head", {loc_valid, loc_addr}, {1'b1, 16'hA000});
        loc_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8 second in order", {loc_valid, loc_addr}, {1'b1, 16'hA001});
        @(posedge clk); @(negedge clk);
        chk("R8 nothing extra", 64'(loc_valid), 64'd0);

        // R9: stalled channel 0 does not block channel 1
        cfg_write(4, 1, 0);
        cfg_write(6, 1, 1);
        ch_ready = 2'b10;
        try_send(4, 16'hC000, acc); chk("R9 ch0 first accepted", 64'(acc), 64'd1);
        try_send(4, 16'hC001, acc); chk("R9 ch0 second accepted", 64'(acc), 64'd1);
        try_send(4, 16'hC002, acc); chk("R9 ch0 full refuses", 64'(acc), 64'd0);
        try_send(6, 16'hC100, acc); chk("R9 ch1 still accepts", 64'(acc), 64'd1);
        chk("R9 ch1 delivers", {ch_valid, ch_addr[AW +: AW]}, {2'b11, 16'hC100});
        chk("R9 ch0 head kept", 64'(ch_addr[0 +: AW]), 64'hC000);
        ch_ready = 2'b11;
        repeat (3) @(negedge clk);

        // R10: parent buffer full refuses read returns
        up_ready = 1'b0;
        try_read(0, 32'h1, acc); chk("R10 first read accepted", 64'(acc), 64'd1);
        try_read(1, 32'h2, acc); chk("R10 second read accepted", 64'(acc), 64'd1);
        try_read(2, 32'h3, acc); chk("R10 full refuses read", 64'(acc), 64'd0);
        chk("R10 oldest read held", {up_valid, up_rank, up_data}, {1'b1, 3'd0, 32'h1});
        up_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R10 second read next", {up_valid, up_rank, up_data}, {1'b1, 3'd1, 32'h2});
        @(posedge clk); @(negedge clk);
        chk("R10 no third read", 64'(up_valid), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule